// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running time of a calendar and raises an alarm request when the time reaches a programmed setting. The calendar supplies the current minute, hour and day of month, all in BCD. It also supplies the current weekday as a one-hot vector and a strobe that pulses once each time the minute advances. Software programs three alarm fields through a small register port: minute, hour, and a shared weekday/day-of-month field. Bit 7 of each field is a "don't care" bit. A control register holds the day-mode select, the sticky alarm flag and the interrupt enable.

The alarm fields are compared only when the minute strobe pulses, so each matching minute gives one event. A match sets the flag, and the flag stays set until software clears it. The active-low request output stays asserted while both the flag and the enable are set. It is never released on a timer.

Top module: `cal_alarm`

## Requirements
- R1: After a synchronous reset, all four registers read 0x00 and `irq_n` is high.
- R2: The register map is: address 0 is the alarm minute, address 1 is the alarm hour, address 2 is the alarm weekday/day field, and address 3 is control. All 8 bits of addresses 0 to 2 read back as written. At address 3, bit 0 is the day-mode select, bit 1 is the flag and bit 2 is the interrupt enable. Bits 7 to 3 of address 3 always read 0.
- R3: On a cycle with `tick_min` high, the flag reads 1 from the next cycle on if every enabled field matches. The minute matches when alarm bits 6:0 equal `cur_min[6:0]`. The hour matches when alarm bits 5:0 equal `cur_hour[5:0]`.
- R4: A field whose bit 7 is 1 counts as matching, whatever the current value is.
- R5: With day-mode select 0, the day field matches when any of alarm bits 6:0 coincides with the set bit of `cur_wday`. Several days may be selected at once, and `cur_mday` has no effect in this mode.
- R6: With day-mode select 1, the day field matches when alarm bits 5:0 equal `cur_mday[5:0]`, and `cur_wday` has no effect in this mode.
- R7: Once set, the flag stays at 1. A write to address 3 with bit 1 at 0 clears it. A write with bit 1 at 1 leaves it unchanged.
- R8: Without `tick_min`, nothing sets the flag. This covers changes of the time inputs and programming the alarm equal to the current time.
- R9: `irq_n` is low while both the flag and the interrupt enable are 1. It stays low across idle cycles until the flag is cleared.
- R10: Writing 0 to the interrupt enable drives `irq_n` high from the next cycle on and leaves the flag unchanged.
- R11: When a matching tick and a flag-clearing write fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_min | input | 1 | One-cycle strobe: minute just advanced |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_wday | input | 7 | Current weekday, one-hot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Alarm request, active low |

## Verification
The bench uses the package defaults: 8-bit registers, a 2-bit address and a 7-day weekday vector. The 7-day vector brings the multi-day mask and the Saturday bit (bit 6) within reach, and the 8-bit width puts the don't-care bit at bit 7. With these values, every field value and every control combination can be reached by direct writes. The bench covers both day modes, don't-care fields, writes with no tick, and a clearing write that collides with a matching tick.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int WDAY_N = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int MDAY_W = 6;
    localparam int DC_BIT = DATA_W - 1;

    localparam int CTL_SEL  = 0;
    localparam int CTL_FLAG = 1;
    localparam int CTL_IE   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MIN  = 2'd0,
        REG_HOUR = 2'd1,
        REG_DAY  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] amin;
        logic [DATA_W-1:0] ahour;
        logic [DATA_W-1:0] aday;
        logic              day_mode;
        logic              irq_en;
    } alarm_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] mday;
        logic [WDAY_N-1:0] wday;
    } now_t;

    function automatic logic [DATA_W-1:0] low_mask(input int w);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
        return m;
    endfunction

    function automatic logic bcd_field_hit(input logic [DATA_W-1:0] areg,
                                           input logic [DATA_W-1:0] cur,
                                           input int w);
        logic [DATA_W-1:0] m;
        m = low_mask(w);
        return areg[DC_BIT] || ((areg & m) == (cur & m));
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag_i,
    output alarm_cfg_t        cfg_o,
    output logic              clr_req_o,
    output logic [DATA_W-1:0] rd_data
);

    alarm_cfg_t cfg_q;
    reg_sel_e   wsel;
    reg_sel_e   rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                REG_MIN:  cfg_q.amin  <= wr_data;
                REG_HOUR: cfg_q.ahour <= wr_data;
                REG_DAY:  cfg_q.aday  <= wr_data;
                REG_CTRL: begin
                    cfg_q.day_mode <= wr_data[CTL_SEL];
                    cfg_q.irq_en   <= wr_data[CTL_IE];
                end
                default: ;
            endcase
        end
    end

    assign clr_req_o = wr_en && (wsel == REG_CTRL) && !wr_data[CTL_FLAG];
    assign cfg_o     = cfg_q;

    always_comb begin
        rd_data = '0;
        case (rsel)
            REG_MIN:  rd_data = cfg_q.amin;
            REG_HOUR: rd_data = cfg_q.ahour;
            REG_DAY:  rd_data = cfg_q.aday;
            REG_CTRL: begin
                rd_data[CTL_SEL]  = cfg_q.day_mode;
                rd_data[CTL_FLAG] = flag_i;
                rd_data[CTL_IE]   = cfg_q.irq_en;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  alarm_cfg_t cfg,
    input  now_t       now,
    output logic       hit
);

    logic [WDAY_N-1:0] wd_hits;
    logic min_ok;
    logic hour_ok;
    logic mday_ok;
    logic wday_ok;
    logic day_ok;

    for (genvar i = 0; i < WDAY_N; i++) begin : g_wday
        assign wd_hits[i] = cfg.aday[i] & now.wday[i];
    end

    assign min_ok  = bcd_field_hit(cfg.amin,  now.min,  MIN_W);
    assign hour_ok = bcd_field_hit(cfg.ahour, now.hour, HOUR_W);
    assign mday_ok = bcd_field_hit(cfg.aday,  now.mday, MDAY_W);
    assign wday_ok = cfg.aday[DC_BIT] || (|wd_hits);
    assign day_ok  = cfg.day_mode ? mday_ok : wday_ok;
    assign hit     = min_ok && hour_ok && day_ok;

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag_o,
    output logic irq_n
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)                flag_q <= 1'b0;
        else if (tick && hit)   flag_q <= 1'b1;
        else if (clr_req)       flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_n  = !(flag_q && irq_en);

    // R3 / R11: a matching tick always leaves the flag set
    p_set_on_match_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> flag_q);

    // R7: only a clearing write removes the flag
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    // R8: no rise of the flag without a tick
    p_no_tick_no_set_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !$rose(flag_q));

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_min,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic [DATA_W-1:0] cur_mday,
    input  logic [WDAY_N-1:0] cur_wday,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    alarm_cfg_t cfg;
    now_t       now;
    logic       hit;
    logic       clr_req;
    logic       flag;

    assign now = '{min: cur_min, hour: cur_hour, mday: cur_mday, wday: cur_wday};

    cal_alarm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .flag_i    (flag),
        .cfg_o     (cfg),
        .clr_req_o (clr_req),
        .rd_data   (rd_data)
    );

    cal_alarm_match u_match (
        .cfg (cfg),
        .now (now),
        .hit (hit)
    );

    cal_alarm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_min),
        .hit     (hit),
        .clr_req (clr_req),
        .irq_en  (cfg.irq_en),
        .flag_o  (flag),
        .irq_n   (irq_n)
    );

    // R10: disabling the interrupt releases the request on the next cycle
    p_ie_release_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_CTRL && !wr_data[CTL_IE]) |=> irq_n);

    // R9: an asserted request holds until a control write
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !(wr_en && wr_addr == REG_CTRL)) |=> !irq_n);

endmodule

// File: tb/cal_alarm_test.sv
module cal_alarm_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_min = 1'b0;
    logic [7:0] cur_min = '0, cur_hour = '0, cur_mday = '0;
    logic [6:0] cur_wday = 7'b0000001;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = 2'd3;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    flag;
        bit    irqn;
        string tag;
    } exp_t;
    exp_t q[$];

    // bench model of the programmed state
    bit [7:0] m_amin = 0, m_ahour = 0, m_aday = 0;
    bit m_sel = 0, m_ie = 0, m_flag = 0;

    always #4 clk = ~clk;

    cal_alarm uut (
        .clk(clk), .rst(rst), .tick_min(tick_min),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_mday(cur_mday),
        .cur_wday(cur_wday), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_n(irq_n)
    );

    function automatic bit model_hit(bit [7:0] mi, bit [7:0] hr, bit [7:0] md, bit [6:0] wd);
        bit ok_m, ok_h, ok_d;
        ok_m = m_amin[7]  || (m_amin[6:0]  == mi[6:0]);
        ok_h = m_ahour[7] || (m_ahour[5:0] == hr[5:0]);
        if (m_aday[7])  ok_d = 1;
        else if (m_sel) ok_d = (m_aday[5:0] == md[5:0]);
        else            ok_d = |(m_aday[6:0] & wd);
        return ok_m && ok_h && ok_d;
    endfunction

    // driver: one cycle of stimulus, called at a falling edge
    task automatic step(input bit tk, input bit [7:0] mi, input bit [7:0] hr,
                        input bit [7:0] md, input bit [6:0] wd,
                        input bit we, input bit [1:0] wa, input bit [7:0] wdat,
                        input string tag);
        exp_t e;
        bit hitv;
        tick_min = tk; cur_min = mi; cur_hour = hr; cur_mday = md; cur_wday = wd;
        wr_en = we; wr_addr = wa; wr_data = wdat;
        hitv = tk && model_hit(mi, hr, md, wd);
        if (hitv) m_flag = 1;
        else if (we && wa == 2'd3 && !wdat[1]) m_flag = 0;
        if (we) begin
            case (wa)
                2'd0: m_amin = wdat;
                2'd1: m_ahour = wdat;
                2'd2: m_aday = wdat;
                default: begin m_sel = wdat[0]; m_ie = wdat[2]; end
            endcase
        end
        e.flag = m_flag; e.irqn = !(m_flag && m_ie); e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        tick_min = 0; wr_en = 0;
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d, input string tag);
        step(0, cur_min, cur_hour, cur_mday, cur_wday, 1, a, d, tag);
    endtask

    task automatic tk(input bit [7:0] mi, input bit [7:0] hr, input bit [7:0] md,
                      input bit [6:0] wd, input string tag);
        step(1, mi, hr, md, wd, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, cur_min, cur_hour, cur_mday, cur_wday, 0, 0, 0, tag);
    endtask

    task automatic rd_check(input bit [1:0] a, input bit [7:0] exp, input string tag);
        @(posedge clk); #3;
        rd_addr = a; #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d read %h expected %h", tag, a, rd_data, exp);
        end
        rd_addr = 2'd3;
        @(negedge clk);
    endtask

    // monitor: compare the state after each driven cycle
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data[1] !== e.flag || irq_n !== e.irqn) begin
                errors++;
                $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
                         e.tag, rd_data[1], irq_n, e.flag, e.irqn);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_check(0, 8'h00, "R1");
        rd_check(1, 8'h00, "R1");
        rd_check(2, 8'h00, "R1");
        rd_check(3, 8'h00, "R1");
        checks++;
        if (irq_n !== 1'b1) begin
            errors++;
            $display("FAIL R1: irq_n=%b expected 1", irq_n);
        end

        // R2 register map
        wr(0, 8'h30, "R2"); wr(1, 8'h12, "R2"); wr(2, 8'h04, "R2");
        wr(3, 8'hFD, "R2");
        rd_check(0, 8'h30, "R2");
        rd_check(1, 8'h12, "R2");
        rd_check(2, 8'h04, "R2");
        rd_check(3, 8'h05, "R2");
        wr(3, 8'h04, "R2");

        // R5 weekday mode: mask bit 2 only
        tk(8'h29, 8'h12, 8'h00, 7'b0000100, "R3 minute mismatch");
        tk(8'h30, 8'h12, 8'h00, 7'b0001000, "R5 other weekday");
        tk(8'h30, 8'h11, 8'h00, 7'b0000100, "R3 hour mismatch");
        tk(8'h30, 8'h12, 8'h17, 7'b0000100, "R3 R5 full match");
        idle("R9 hold"); idle("R9 hold");
        wr(3, 8'h06, "R7 write one keeps flag");
        wr(3, 8'h02, "R10 ie off keeps flag");
        idle("R10 released");
        wr(3, 8'h04, "R7 clear");

        // R8 alarm equal to now without a tick
        step(0, 8'h31, 8'h12, 8'h00, 7'b0000100, 0, 0, 0, "R8 inputs move");
        wr(0, 8'h31, "R8 program to now");
        idle("R8 still clear");
        tk(8'h31, 8'h12, 8'h00, 7'b0000100, "R8 next tick fires");
        wr(3, 8'h04, "R7 clear");

        // R4 don't-care fields
        wr(0, 8'h80, "R4");
        tk(8'h05, 8'h12, 8'h00, 7'b0000100, "R4 minute ignored");
        wr(3, 8'h04, "R7 clear");
        wr(1, 8'h80, "R4");
        wr(2, 8'h41, "R5 multi-day mask");
        tk(8'h07, 8'h03, 8'h00, 7'b0000100, "R5 day not in mask");
        tk(8'h08, 8'h03, 8'h00, 7'b1000000, "R5 saturday bit");
        wr(3, 8'h04, "R7 clear");
        tk(8'h09, 8'h03, 8'h00, 7'b0000001, "R5 sunday bit");
        wr(3, 8'h04, "R7 clear");
        wr(2, 8'h80, "R4");
        tk(8'h10, 8'h22, 8'h00, 7'b0010000, "R4 all ignored");
        wr(3, 8'h04, "R7 clear");

        // R6 day-of-month mode
        wr(3, 8'h05, "R6 select");
        wr(2, 8'h15, "R6");
        tk(8'h11, 8'h01, 8'h14, 7'b0000001, "R6 mday mismatch");
        tk(8'h12, 8'h01, 8'h15, 7'b0000010, "R6 mday match");
        wr(3, 8'h05, "R7 clear");
        tk(8'h13, 8'h01, 8'h31, 7'b0010101, "R6 weekday ignored");

        // R11 matching tick collides with a clearing write
        step(1, 8'h14, 8'h01, 8'h15, 7'b0000001, 1, 3, 8'h05, "R11 set wins");
        idle("R11 hold");
        wr(3, 8'h05, "R7 clear");
        idle("R7 cleared");

        @(posedge clk); #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule